// File: doc/BRIEF.md
# Paired Interval Timer with PWM and 64-bit Chaining

This block holds two equal-width down/up counters, lane A and lane B, and couples them in one of three ways chosen by `pair_mode`. In split mode each lane is an independent interval timer. Each lane expires at its terminal value and then either reloads or stops. In PWM mode lane A sets the period and lane B sets the high time of one output, `pwm_out`. In chained mode the two lanes form one counter of twice the width. Lane A is the lower half, and lane A's control pins alone drive it. The chained counter either generates an expiry or captures its full value on an external trigger.

A disabled lane continuously copies its load value, so software writes a load value and then sets the enable. Both lanes' interrupt flags feed a single `irq` output. All pins are plain control and status levels sampled on `clk`. There is no data stream, so no valid/ready handshake or back-pressure applies. The lane length below is `M - L` when counting up and `L + 1` when counting down, with `M = 2^WIDTH` and `L` the load value.

Top module: `paired_tmr`

## Requirements
- R1: While `rst_n` is low, `pwm_out`, `irq`, `count_value` and `capture_value` are all zero.
- R2: A disabled lane takes its load value on every clock. An enabled lane moves by one per clock from that value: up when its count-up pin is 1, down when it is 0. `count_value[WIDTH-1:0]` is lane A and `count_value[2*WIDTH-1:WIDTH]` is lane B.
- R3: In split mode (`pair_mode` = 00), an enabled lane expires while it holds its terminal value (all ones counting up, zero counting down). It then sets its interrupt flag. With autoreload = 1 it reloads its load value, so expiries repeat every lane length. With autoreload = 0 it stays at the terminal value and stops counting.
- R4: In PWM mode (`pair_mode` = 01) with both lanes enabled, count the clocks after the enable as n. `pwm_out` is low for n < lenA. For n ≥ lenA it is high exactly when ((n − lenA) mod lenA) < lenB. Both lanes auto-reload whatever their autoreload pins say.
- R5: In PWM mode, if lenB ≥ lenA, `pwm_out` stays high from its first rise onward.
- R6: `pwm_out` goes low on the clock after the mode is not PWM or either lane is disabled.
- R7: In chained mode (`pair_mode[1]` = 1), `count_value` is one 2·WIDTH counter. The upper half steps only when the lower half wraps: from all ones to zero counting up, or from zero to all ones counting down. In generate operation (`a_capture` = 0) the counter expires at its full terminal value and sets lane A's flag. It then reloads `{b_load, a_load}` when `a_autoreload` = 1, or holds when `a_autoreload` = 0.
- R8: In chained mode, `b_enable`, `b_count_up`, `b_autoreload` and `b_irq_en` have no effect on counting or on `irq`.
- R9: In chained capture operation (`a_capture` = 1), the counter runs freely and wraps. A clock with `capture_trig` high copies the whole current `count_value` into `capture_value` on that edge and sets lane A's flag.
- R10: In chained capture with `a_autoreload` = 0, a set lane A flag blocks further captures until the flag is cleared. With `a_autoreload` = 1, every trigger overwrites `capture_value`.
- R11: `irq` is (flag A and `a_irq_en`) or (flag B and `b_irq_en`, in split or PWM mode only). `irq_clear[0]` clears flag A and `irq_clear[1]` clears flag B. A flag stays set while its interrupt enable is low, and a set in the same clock beats a clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pair_mode | input | 2 | 00 split, 01 PWM, 1x chained |
| a_enable | input | 1 | Lane A run enable (chained: whole counter) |
| a_count_up | input | 1 | Lane A direction, 1 = up |
| a_autoreload | input | 1 | Lane A reload on expiry / capture overwrite |
| a_capture | input | 1 | Chained mode: 1 = capture, 0 = generate |
| a_irq_en | input | 1 | Lane A interrupt enable |
| b_enable | input | 1 | Lane B run enable |
| b_count_up | input | 1 | Lane B direction, 1 = up |
| b_autoreload | input | 1 | Lane B reload on expiry |
| b_irq_en | input | 1 | Lane B interrupt enable |
| a_load | input | WIDTH | Lane A load value |
| b_load | input | WIDTH | Lane B load value |
| capture_trig | input | 1 | External capture event |
| irq_clear | input | 2 | Write-one clear of flag A (bit 0) and flag B (bit 1) |
| pwm_out | output | 1 | Pulse-width modulated output |
| irq | output | 1 | Combined interrupt |
| count_value | output | 2*WIDTH | {lane B, lane A} count |
| capture_value | output | 2*WIDTH | Last captured chained count |

## Verification
A wrong carry between the halves shows up in `count_value` within one clock of a lower-half wrap. A lost reload or a missing stop bends the sequence on the clock after expiry. A mis-phased high-time lane moves the falling edge of `pwm_out` within the first full period, so every PWM run is compared sample by sample against the arithmetic waveform for each pair of load values and directions. A capture that tears or a stuck flag appears at `capture_value` or `irq` on the clock after the trigger or the clear.

// File: rtl/paired_tmr_pkg.sv
package paired_tmr_pkg;
  localparam logic [1:0] MODE_SPLIT = 2'b00;
  localparam logic [1:0] MODE_PWM   = 2'b01;
  localparam int         CHAIN_BIT  = 1;
  localparam int         LANES      = 2;
endpackage

// File: rtl/paired_tmr_lane.sv
module paired_tmr_lane #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             step,
  input  logic             up,
  input  logic             reload_now,
  input  logic             stop_now,
  input  logic [WIDTH-1:0] load_val,
  output logic [WIDTH-1:0] cnt,
  output logic             at_term,
  output logic             stopped
);
  assign at_term = up ? (cnt == {WIDTH{1'b1}}) : (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      stopped <= 1'b0;
    end else if (!en) begin
      cnt     <= load_val;
      stopped <= 1'b0;
    end else if (reload_now) begin
      cnt <= load_val;
    end else if (stop_now) begin
      stopped <= 1'b1;
    end else if (step && !stopped) begin
      cnt <= up ? cnt + 1'b1 : cnt - 1'b1;
    end
  end
endmodule

// File: rtl/paired_tmr_pwm.sv
module paired_tmr_pwm (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic period_done,
  input  logic high_done,
  output logic pwm_out
);
  always_ff @(posedge clk) begin
    if (!rst_n)           pwm_out <= 1'b0;
    else if (!active)     pwm_out <= 1'b0;
    else if (period_done) pwm_out <= 1'b1;
    else if (high_done)   pwm_out <= 1'b0;
  end
endmodule

// File: rtl/paired_tmr_irq.sv
module paired_tmr_irq (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       set_a,
  input  logic       set_b,
  input  logic [1:0] clear,
  input  logic       ie_a,
  input  logic       ie_b,
  output logic       flag_a,
  output logic       flag_b,
  output logic       irq
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_a <= 1'b0;
      flag_b <= 1'b0;
    end else begin
      if (set_a)         flag_a <= 1'b1;
      else if (clear[0]) flag_a <= 1'b0;
      if (set_b)         flag_b <= 1'b1;
      else if (clear[1]) flag_b <= 1'b0;
    end
  end

  assign irq = (flag_a & ie_a) | (flag_b & ie_b);
endmodule

// File: rtl/paired_tmr_capture.sv
module paired_tmr_capture #(
  parameter int CW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic [CW-1:0] count_in,
  output logic [CW-1:0] cap_out
);
  always_ff @(posedge clk) begin
    if (!rst_n)    cap_out <= '0;
    else if (take) cap_out <= count_in;
  end
endmodule

// File: rtl/paired_tmr.sv
module paired_tmr
  import paired_tmr_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         pair_mode,
  input  logic               a_enable,
  input  logic               a_count_up,
  input  logic               a_autoreload,
  input  logic               a_capture,
  input  logic               a_irq_en,
  input  logic               b_enable,
  input  logic               b_count_up,
  input  logic               b_autoreload,
  input  logic               b_irq_en,
  input  logic [WIDTH-1:0]   a_load,
  input  logic [WIDTH-1:0]   b_load,
  input  logic               capture_trig,
  input  logic [1:0]         irq_clear,
  output logic               pwm_out,
  output logic               irq,
  output logic [2*WIDTH-1:0] count_value,
  output logic [2*WIDTH-1:0] capture_value
);
  localparam int CW = 2 * WIDTH;

  logic chain, pwm_mode;
  assign chain    = pair_mode[CHAIN_BIT];
  assign pwm_mode = (pair_mode == MODE_PWM);

  logic [WIDTH-1:0] lane_load [LANES];
  logic [WIDTH-1:0] lane_cnt  [LANES];
  logic [LANES-1:0] lane_en, lane_up, lane_step, lane_rl, lane_stop;
  logic [LANES-1:0] lane_term, lane_stopped;

  assign lane_load[0] = a_load;
  assign lane_load[1] = b_load;
  assign lane_en[0]   = a_enable;
  assign lane_en[1]   = chain ? a_enable : b_enable;
  assign lane_up[0]   = a_count_up;
  assign lane_up[1]   = chain ? a_count_up : b_count_up;

  // Live terminal: lane running and sitting on its terminal value
  logic live_a, live_b;
  assign live_a = lane_en[0] & lane_term[0] & ~lane_stopped[0];
  assign live_b = lane_en[1] & lane_term[1] & ~lane_stopped[1];

  logic exp_a, exp_b, exp_chain, rl_a, rl_b, restart_b;
  assign exp_a     = ~chain & live_a;
  assign exp_b     = ~chain & live_b;
  assign exp_chain = chain & ~a_capture & live_a & lane_term[1];
  assign rl_a      = pwm_mode | a_autoreload;
  assign rl_b      = pwm_mode | b_autoreload;
  assign restart_b = pwm_mode & exp_a;

  always_comb begin
    lane_step[0] = 1'b1;
    lane_step[1] = chain ? live_a : 1'b1;
    if (chain) begin
      lane_rl   = {LANES{exp_chain & a_autoreload}};
      lane_stop = {LANES{exp_chain & ~a_autoreload}};
    end else begin
      lane_rl[0]   = exp_a & rl_a;
      lane_stop[0] = exp_a & ~rl_a;
      lane_rl[1]   = (exp_b & rl_b) | restart_b;
      lane_stop[1] = exp_b & ~rl_b & ~restart_b;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    paired_tmr_lane #(.WIDTH(WIDTH)) u_lane (
      .clk        (clk),
      .rst_n      (rst_n),
      .en         (lane_en[g]),
      .step       (lane_step[g]),
      .up         (lane_up[g]),
      .reload_now (lane_rl[g]),
      .stop_now   (lane_stop[g]),
      .load_val   (lane_load[g]),
      .cnt        (lane_cnt[g]),
      .at_term    (lane_term[g]),
      .stopped    (lane_stopped[g])
    );
  end

  assign count_value = {lane_cnt[1], lane_cnt[0]};

  logic flag_a, flag_b, cap_take;
  assign cap_take = chain & a_capture & a_enable & capture_trig &
                    (~flag_a | a_autoreload);

  paired_tmr_irq u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_a  (exp_a | exp_chain | cap_take),
    .set_b  (exp_b),
    .clear  (irq_clear),
    .ie_a   (a_irq_en),
    .ie_b   (b_irq_en & ~chain),
    .flag_a (flag_a),
    .flag_b (flag_b),
    .irq    (irq)
  );

  paired_tmr_pwm u_pwm (
    .clk         (clk),
    .rst_n       (rst_n),
    .active      (pwm_mode & a_enable & b_enable),
    .period_done (exp_a),
    .high_done   (exp_b),
    .pwm_out     (pwm_out)
  );

  paired_tmr_capture #(.CW(CW)) u_cap (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (cap_take),
    .count_in (count_value),
    .cap_out  (capture_value)
  );
endmodule

// File: rtl/paired_tmr_chk.sv
module paired_tmr_chk #(
  parameter int WIDTH = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic [1:0]         pair_mode,
  input logic               a_enable,
  input logic               a_count_up,
  input logic               a_autoreload,
  input logic               a_capture,
  input logic               a_irq_en,
  input logic               b_enable,
  input logic               b_irq_en,
  input logic               capture_trig,
  input logic [1:0]         irq_clear,
  input logic               pwm_out,
  input logic               irq,
  input logic [2*WIDTH-1:0] count_value,
  input logic [2*WIDTH-1:0] capture_value,
  input logic               flag_a
);
  localparam int CW = 2 * WIDTH;

  assert_pwm_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(pair_mode == 2'b01 && a_enable && b_enable) |=> !pwm_out);

  assert_upper_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_mode[1] && a_enable && a_count_up && a_capture &&
     count_value[WIDTH-1:0] != {WIDTH{1'b1}})
    |=> count_value[CW-1:WIDTH] == $past(count_value[CW-1:WIDTH]));

  assert_capture_latch_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_mode[1] && a_enable && a_capture && capture_trig &&
     (!flag_a || a_autoreload))
    |=> capture_value == $past(count_value));

  assert_capture_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_a && !a_autoreload && !irq_clear[0]) |=> $stable(capture_value));

  assert_irq_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!a_irq_en && (pair_mode[1] || !b_irq_en)) |-> !irq);
endmodule

bind paired_tmr paired_tmr_chk #(.WIDTH(WIDTH)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .pair_mode     (pair_mode),
  .a_enable      (a_enable),
  .a_count_up    (a_count_up),
  .a_autoreload  (a_autoreload),
  .a_capture     (a_capture),
  .a_irq_en      (a_irq_en),
  .b_enable      (b_enable),
  .b_irq_en      (b_irq_en),
  .capture_trig  (capture_trig),
  .irq_clear     (irq_clear),
  .pwm_out       (pwm_out),
  .irq           (irq),
  .count_value   (count_value),
  .capture_value (capture_value),
  .flag_a        (flag_a)
);

// File: tb/paired_tmr_tb.sv
`timescale 1ns/1ps
module paired_tmr_tb;
  localparam int W  = 4;
  localparam int M  = 1 << W;
  localparam int CW = 2 * W;
  localparam int MC = 1 << CW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [1:0]    pair_mode;
  logic          a_enable, a_count_up, a_autoreload, a_capture, a_irq_en;
  logic          b_enable, b_count_up, b_autoreload, b_irq_en;
  logic [W-1:0]  a_load, b_load;
  logic          capture_trig;
  logic [1:0]    irq_clear;
  logic          pwm_out, irq;
  logic [CW-1:0] count_value, capture_value;

  paired_tmr #(.WIDTH(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .pair_mode(pair_mode),
    .a_enable(a_enable), .a_count_up(a_count_up), .a_autoreload(a_autoreload),
    .a_capture(a_capture), .a_irq_en(a_irq_en),
    .b_enable(b_enable), .b_count_up(b_count_up), .b_autoreload(b_autoreload),
    .b_irq_en(b_irq_en), .a_load(a_load), .b_load(b_load),
    .capture_trig(capture_trig), .irq_clear(irq_clear),
    .pwm_out(pwm_out), .irq(irq), .count_value(count_value),
    .capture_value(capture_value)
  );

  always #2.5 clk = ~clk;

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 1'b0;

  task automatic check(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int lane_len(int l, bit up);
    return up ? (M - l) : (l + 1);
  endfunction

  task automatic idle();
    @(negedge clk);
    a_enable = 1'b0; b_enable = 1'b0; capture_trig = 1'b0; irq_clear = 2'b11;
    @(negedge clk);
    irq_clear = 2'b00;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog R1..all actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int n, v, e, lenc;
    rst_n = 1'b0; pair_mode = 2'b00;
    a_enable = 0; a_count_up = 0; a_autoreload = 0; a_capture = 0; a_irq_en = 0;
    b_enable = 0; b_count_up = 0; b_autoreload = 0; b_irq_en = 0;
    a_load = '0; b_load = '0; capture_trig = 0; irq_clear = 2'b00;
    repeat (3) @(negedge clk);
    check(pwm_out == 1'b0, "R1 pwm reset", pwm_out, 0);
    check(irq == 1'b0, "R1 irq reset", irq, 0);
    check(count_value == '0, "R1 count reset", count_value, 0);
    check(capture_value == '0, "R1 capture reset", capture_value, 0);
    rst_n = 1'b1;

    // Split mode, lane A: every load, direction and reload choice
    for (int up = 0; up < 2; up++)
      for (int rl = 0; rl < 2; rl++)
        for (int l = 0; l < M; l++) begin
          idle();
          pair_mode = 2'b00; a_load = W'(l); b_load = 4'd9;
          a_count_up = up[0]; a_autoreload = rl[0]; a_irq_en = 1; b_irq_en = 0;
          @(negedge clk);
          a_enable = 1'b1;
          for (int k = 1; k <= 2 * lane_len(l, up[0]) + 1; k++) begin
            @(negedge clk);
            if (rl != 0) e = up != 0 ? l + k % lane_len(l, up[0]) : l - k % lane_len(l, up[0]);
            else e = up != 0 ? ((l + k > M - 1) ? M - 1 : l + k) : ((l - k < 0) ? 0 : l - k);
            check(count_value[W-1:0] == W'(e),
                  k < lane_len(l, up[0]) ? "R2 lane A step" : "R3 lane A expiry",
                  count_value[W-1:0], e);
            check(count_value[CW-1:W] == 4'd9, "R2 disabled lane B holds load",
                  count_value[CW-1:W], 9);
            check(irq == (k >= lane_len(l, up[0])), "R3 lane A flag", irq,
                  k >= lane_len(l, up[0]));
          end
        end

    // R11: clear and enable gating
    idle();
    a_load = 4'd14; a_count_up = 1; a_autoreload = 0; a_irq_en = 1;
    @(negedge clk); a_enable = 1;
    repeat (4) @(negedge clk);
    check(irq == 1'b1, "R3 stop sets flag", irq, 1);
    irq_clear = 2'b01;
    @(negedge clk); irq_clear = 2'b00;
    check(irq == 1'b0, "R11 clear flag A", irq, 0);
    idle();
    a_irq_en = 0;
    @(negedge clk); a_enable = 1;
    repeat (5) @(negedge clk);
    check(irq == 1'b0, "R11 gated by enable", irq, 0);
    a_irq_en = 1;
    @(negedge clk);
    check(irq == 1'b1, "R11 flag kept while gated", irq, 1);

    // Lane B in split mode
    idle();
    a_irq_en = 0; b_load = 4'd12; b_count_up = 1; b_autoreload = 1; b_irq_en = 1;
    @(negedge clk); b_enable = 1;
    for (int k = 1; k <= 9; k++) begin
      @(negedge clk);
      check(count_value[CW-1:W] == W'(12 + k % 4), "R3 lane B reload",
            count_value[CW-1:W], 12 + k % 4);
      check(irq == (k >= 4), "R11 lane B irq", irq, k >= 4);
    end
    b_irq_en = 0;

    // PWM: all load pairs and direction pairs
    for (int u0 = 0; u0 < 2; u0++)
      for (int u1 = 0; u1 < 2; u1++)
        for (int l0 = 0; l0 < M; l0++)
          for (int l1 = 0; l1 < M; l1++) begin
            int la, lb, mism, first_act, first_exp;
            idle();
            pair_mode = 2'b01; a_autoreload = 0; b_autoreload = 0;
            a_irq_en = 0; b_irq_en = 0;
            a_count_up = u0[0]; b_count_up = u1[0];
            a_load = W'(l0); b_load = W'(l1);
            la = lane_len(l0, u0[0]); lb = lane_len(l1, u1[0]);
            mism = 0; first_act = 0; first_exp = 0;
            @(negedge clk);
            a_enable = 1; b_enable = 1;
            for (int k = 1; k <= 3 * la + 2; k++) begin
              bit ex;
              @(negedge clk);
              ex = (k >= la) && (((k - la) % la) < lb);
              if (pwm_out != ex) begin
                if (mism == 0) begin first_act = pwm_out; first_exp = ex; end
                mism++;
              end
            end
            check(mism == 0, lb >= la ? "R5 pwm steady high" : "R4 pwm waveform",
                  first_act, first_exp);
          end

    // R6: disable either lane forces low
    idle();
    pair_mode = 2'b01; a_load = 4'd10; b_load = 4'd4; a_count_up = 1; b_count_up = 1;
    @(negedge clk); a_enable = 1; b_enable = 1;
    repeat (8) @(negedge clk);
    check(pwm_out == 1'b1, "R5 high before disable", pwm_out, 1);
    b_enable = 0;
    @(negedge clk);
    check(pwm_out == 1'b0, "R6 lane B disabled", pwm_out, 0);
    b_enable = 1; a_enable = 0;
    repeat (3) @(negedge clk);
    check(pwm_out == 1'b0, "R6 lane A disabled", pwm_out, 0);

    // Chained generate sweep with conflicting lane B controls
    for (int up = 0; up < 2; up++)
      for (v = 0; v < MC; v += 15) begin
        idle();
        pair_mode = 2'b10; a_capture = 0; a_autoreload = 1; a_irq_en = 1;
        a_count_up = up[0]; b_count_up = ~up[0]; b_enable = 0; b_irq_en = 1;
        b_autoreload = 0; a_load = W'(v); b_load = W'(v >> W);
        lenc = up != 0 ? MC - v : v + 1;
        @(negedge clk); a_enable = 1;
        for (int k = 1; k <= lenc + 2; k++) begin
          @(negedge clk);
          e = up != 0 ? v + k % lenc : v - k % lenc;
          check(count_value == CW'(e), "R7 chained count", count_value, e);
          check(irq == (k >= lenc), "R7 chained expiry flag", irq, k >= lenc);
        end
      end

    // R8: lane B controls ignored
    idle();
    pair_mode = 2'b10; a_irq_en = 0; b_irq_en = 1; b_enable = 1; b_count_up = 0;
    a_count_up = 1; a_autoreload = 1; a_load = 4'hC; b_load = 4'hF;
    @(negedge clk);
    repeat (3) @(negedge clk);
    check(count_value == 8'hFC, "R8 lane B enable ignored", count_value, 8'hFC);
    a_enable = 1;
    for (int k = 1; k <= 10; k++) begin
      @(negedge clk);
      check(count_value == CW'(8'hFC + k % 4), "R8 chained follows lane A",
            count_value, 8'hFC + k % 4);
      check(irq == 1'b0, "R8 lane B irq enable ignored", irq, 0);
    end

    // R7 hold without reload
    idle();
    a_autoreload = 0; a_irq_en = 1; a_load = 4'hD; b_load = 4'hF;
    @(negedge clk); a_enable = 1;
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk);
      e = (8'hFD + k > MC - 1) ? MC - 1 : 8'hFD + k;
      check(count_value == CW'(e), "R7 chained hold", count_value, e);
    end

    // R9: capture every cycle across wraps, both directions
    for (int up = 0; up < 2; up++) begin
      idle();
      v = up != 0 ? 8'hFA : 8'h05;
      pair_mode = 2'b10; a_capture = 1; a_autoreload = 1; a_irq_en = 1;
      a_count_up = up[0]; a_load = W'(v); b_load = W'(v >> W);
      @(negedge clk);
      a_enable = 1; capture_trig = 1;
      for (int k = 0; k < 40; k++) begin
        e = (up != 0 ? v + k : v - k + MC) % MC;
        check(count_value == CW'(e), "R9 free running count", count_value, e);
        @(negedge clk);
        check(capture_value == CW'(e), "R9 full-width capture", capture_value, e);
      end
      capture_trig = 0;
      check(irq == 1'b1, "R9 capture flag", irq, 1);
    end

    // R10: hold until cleared
    idle();
    v = 8'h30; a_autoreload = 0; a_count_up = 1; a_load = 4'h0; b_load = 4'h3;
    @(negedge clk); a_enable = 1; n = 0;
    repeat (5) begin @(negedge clk); n++; end
    capture_trig = 1; @(negedge clk); n++; capture_trig = 0;
    check(capture_value == CW'(v + 5), "R9 first capture", capture_value, v + 5);
    repeat (3) begin @(negedge clk); n++; end
    capture_trig = 1; @(negedge clk); n++; capture_trig = 0;
    check(capture_value == CW'(v + 5), "R10 no overwrite while flagged",
          capture_value, v + 5);
    repeat (2) begin @(negedge clk); n++; end
    irq_clear = 2'b01; @(negedge clk); n++; irq_clear = 2'b00;
    check(irq == 1'b0, "R11 capture flag cleared", irq, 0);
    @(negedge clk); n++;
    capture_trig = 1; @(negedge clk); n++; capture_trig = 0;
    check(capture_value == CW'(v + 14), "R10 capture after clear",
          capture_value, v + 14);
    check(n == 15, "R10 sequence length", n, 15);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule